// File: doc/BRIEF.md
# Holdover Frequency Controller

This block sits next to the loop filter of a digital PLL. It produces the frequency word that the controlled oscillator must use whenever the reference can no longer be trusted. Only the integral-path word of the loop filter is used. The proportional path never reaches the held value, so recent phase disturbances cannot bend it. While the loop is locked, the integral word is captured at regular intervals into a short history. The same captures are also accumulated into a one-second average.

Two kinds of holdover exist. A fast reference-failure strobe places the block in mini-holdover on the next clock edge. This state lasts until the reference is reported active again or the full holdover state begins. Full holdover follows a level request from the surrounding state machine. In automatic mode the held word is either the aged snapshot (instantaneous) or the one-second average (averaged, once one exists). In free-run mode the held word is the programmable master-clock offset, which means the oscillator runs at its nominal frequency plus that offset.

All frequency words are unsigned offsets from nominal. A millisecond tick sets the capture interval.

Top module: `holdover_freq_ctrl`

## Requirements
- R1: Every SNAP_TICKS-th millisecond tick since reset is a capture boundary. At a boundary the integral word enters a two-entry history, but only while `locked_i` is 1 and no holdover is active. At other times the boundary is skipped.
- R2: On entry into holdover in instantaneous automatic mode, the held word is the older history entry. That entry is the word captured at the boundary before the most recent capture.
- R3: Once AVG_SNAPS captures have accumulated, the average is floor(sum × RECIP / 2^AVG_FRAC), where RECIP = floor(2^AVG_FRAC / AVG_SNAPS). At that moment `hold_ready_o` rises one cycle after the completing boundary and then stays at 1 until reset. Later full windows replace the average.
- R4: When full holdover begins with `avg_mode_i`=1, the held word is the average if `hold_ready_o` is 1. Otherwise it is the older snapshot.
- R5: While `free_run_i`=1, `hold_freq_o` equals `mclk_offset_i`, whatever the value of `avg_mode_i`.
- R6: A `ref_fail_i` pulse sets `mini_hold_o` on the next edge, unless `ref_active_i` or `holdover_req_i` is also 1. Mini-holdover always freezes the older snapshot, even in averaged mode.
- R7: `ref_active_i` or `holdover_req_i` clears `mini_hold_o` on the next edge.
- R8: When full holdover begins during mini-holdover, the held word is selected again using the full-holdover rule (R4).
- R9: While any holdover lasts, the held word does not change, and captures and accumulation pause.
- R10: A cycle with `locked_i`=0 discards the partial averaging window.
- R11: `hold_ready_lat_o` is set on a rising edge of `hold_ready_o`. It is cleared by `ready_clr_i`. A set in the same cycle as a clear wins.
- R12: After reset, `hold_freq_o` (with free-run off), `hold_ready_o`, `hold_ready_lat_o` and `mini_hold_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| integ_freq_i | input | FREQ_W | Integral-path frequency word |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| locked_i | input | 1 | Loop is locked |
| ref_fail_i | input | 1 | Fast reference-failure strobe |
| ref_active_i | input | 1 | Selected reference is active again |
| holdover_req_i | input | 1 | Full holdover state, level |
| free_run_i | input | 1 | 1: free-run holdover, 0: automatic |
| avg_mode_i | input | 1 | 1: averaged, 0: instantaneous |
| mclk_offset_i | input | FREQ_W | Master-clock offset word for free-run |
| ready_clr_i | input | 1 | Write-one-to-clear for the latched ready flag |
| hold_freq_o | output | FREQ_W | Frequency word to use in holdover |
| hold_ready_o | output | 1 | Valid average exists (real-time) |
| hold_ready_lat_o | output | 1 | Latched ready flag |
| mini_hold_o | output | 1 | Mini-holdover is active |

## Verification
The bench builds the block with FREQ_W=16, SNAP_TICKS=2, AVG_SNAPS=5 and AVG_FRAC=16. A capture then takes two ticks and an averaging window takes ten. This makes it cheap to sweep many value sets through full averaging windows, each starting from reset. Each sweep checks the snapshot age, the reciprocal-scaled average, the fallback before ready, and the switch from mini to full holdover. Lock loss in mid-window, captures paused during holdover, free-run override and set-over-clear priority are each driven in a few cycles.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  typedef enum logic {
    SRC_SNAP = 1'b0,
    SRC_AVG  = 1'b1
  } hold_src_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hfc_snap_hist.sv
module hfc_snap_hist #(
  parameter int unsigned FREQ_W     = 32,
  parameter int unsigned SNAP_TICKS = 50,
  parameter int unsigned HIST_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              capture_en_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              boundary_o,
  output logic [FREQ_W-1:0] oldest_o
);
  localparam int unsigned DIV_W = hfc_pkg::cnt_width(SNAP_TICKS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SNAP_TICKS - 1);

  logic [DIV_W-1:0]  div_q;
  logic [FREQ_W-1:0] hist_q [HIST_DEPTH];
  logic              load;

  assign boundary_o = tick_i && (div_q == DIV_LAST);
  assign load       = boundary_o && capture_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_i) div_q <= boundary_o ? '0 : div_q + 1'b1;
  end

  for (genvar g = 0; g < HIST_DEPTH; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   hist_q[g] <= '0;
      else if (load) hist_q[g] <= (g == 0) ? freq_i : hist_q[(g == 0) ? 0 : g-1];
    end
    if (g > 0) begin : g_chk
      // history shifts on every enabled boundary
      p_hist_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |=> hist_q[g] == $past(hist_q[g-1]));
    end
  end

  assign oldest_o = hist_q[HIST_DEPTH-1];

  p_div_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DIV_LAST);
  p_hist_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(hist_q[0]));
endmodule

// File: rtl/hfc_avg.sv
module hfc_avg #(
  parameter int unsigned FREQ_W    = 32,
  parameter int unsigned AVG_SNAPS = 20,
  parameter int unsigned AVG_FRAC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              en_i,
  input  logic              locked_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [FREQ_W-1:0] avg_o,
  output logic              ready_o
);
  localparam int unsigned ACC_W   = FREQ_W + hfc_pkg::cnt_width(AVG_SNAPS + 1);
  localparam int unsigned CNT_W   = hfc_pkg::cnt_width(AVG_SNAPS);
  localparam int unsigned RECIP   = (1 << AVG_FRAC) / AVG_SNAPS;
  localparam int unsigned RECIP_W = AVG_FRAC + 1;
  localparam int unsigned PROD_W  = ACC_W + RECIP_W;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(AVG_SNAPS - 1);

  logic [ACC_W-1:0]  acc_q, acc_sum;
  logic [CNT_W-1:0]  cnt_q;
  logic [PROD_W-1:0] prod;
  logic [FREQ_W-1:0] avg_q;
  logic              ready_q, take, window_done;

  assign take        = boundary_i && en_i;
  assign window_done = take && (cnt_q == CNT_LAST);
  assign acc_sum     = acc_q + ACC_W'(freq_i);
  assign prod        = PROD_W'(acc_sum) * PROD_W'(RECIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      avg_q   <= '0;
      ready_q <= 1'b0;
    end else if (!locked_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (window_done) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      avg_q   <= prod[AVG_FRAC +: FREQ_W];
      ready_q <= 1'b1;
    end else if (take) begin
      acc_q <= acc_sum;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign avg_o   = avg_q;
  assign ready_o = ready_q;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  p_acc_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> (acc_q == '0) && (cnt_q == '0));
  p_ready_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q);
  p_avg_pause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(avg_q));
endmodule

// File: rtl/hfc_ready_latch.sv
module hfc_ready_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rt_i,
  input  logic clr_i,
  output logic lat_o
);
  logic rt_d, lat_q, rise;

  assign rise = rt_i && !rt_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_d  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      rt_d <= rt_i;
      if (rise)       lat_q <= 1'b1;
      else if (clr_i) lat_q <= 1'b0;
    end
  end

  assign lat_o = lat_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> lat_q);
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise) |=> !lat_q);
endmodule

// File: rtl/holdover_freq_ctrl.sv
module holdover_freq_ctrl #(
  parameter int unsigned FREQ_W     = 32,
  parameter int unsigned SNAP_TICKS = 50,
  parameter int unsigned AVG_SNAPS  = 20,
  parameter int unsigned AVG_FRAC   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREQ_W-1:0] integ_freq_i,
  input  logic              ms_tick_i,
  input  logic              locked_i,
  input  logic              ref_fail_i,
  input  logic              ref_active_i,
  input  logic              holdover_req_i,
  input  logic              free_run_i,
  input  logic              avg_mode_i,
  input  logic [FREQ_W-1:0] mclk_offset_i,
  input  logic              ready_clr_i,
  output logic [FREQ_W-1:0] hold_freq_o,
  output logic              hold_ready_o,
  output logic              hold_ready_lat_o,
  output logic              mini_hold_o
);
  import hfc_pkg::*;

  localparam int unsigned HIST_DEPTH = 2;

  logic              mini_q, mini_d, full_q, hold_q, hold_d;
  logic              boundary, upd_en, freeze, avg_ready;
  logic [FREQ_W-1:0] old_snap, avg_val, frozen_q;
  hold_src_e         src;

  assign upd_en = locked_i && !hold_q;

  hfc_snap_hist #(
    .FREQ_W(FREQ_W), .SNAP_TICKS(SNAP_TICKS), .HIST_DEPTH(HIST_DEPTH)
  ) i_hist (
    .clk_i, .rst_ni,
    .tick_i      (ms_tick_i),
    .capture_en_i(upd_en),
    .freq_i      (integ_freq_i),
    .boundary_o  (boundary),
    .oldest_o    (old_snap)
  );

  hfc_avg #(
    .FREQ_W(FREQ_W), .AVG_SNAPS(AVG_SNAPS), .AVG_FRAC(AVG_FRAC)
  ) i_avg (
    .clk_i, .rst_ni,
    .boundary_i(boundary),
    .en_i      (upd_en),
    .locked_i  (locked_i),
    .freq_i    (integ_freq_i),
    .avg_o     (avg_val),
    .ready_o   (avg_ready)
  );

  hfc_ready_latch i_lat (
    .clk_i, .rst_ni,
    .rt_i (avg_ready),
    .clr_i(ready_clr_i),
    .lat_o(hold_ready_lat_o)
  );

  always_comb begin
    if (holdover_req_i || ref_active_i) mini_d = 1'b0;
    else if (ref_fail_i)                mini_d = 1'b1;
    else                                mini_d = mini_q;
  end

  assign hold_d = holdover_req_i || mini_d;
  // re-select on any hold entry and on promotion to full holdover
  assign freeze = (hold_d && !hold_q) || (holdover_req_i && !full_q);
  assign src    = (holdover_req_i && avg_mode_i && avg_ready) ? SRC_AVG : SRC_SNAP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mini_q   <= 1'b0;
      full_q   <= 1'b0;
      hold_q   <= 1'b0;
      frozen_q <= '0;
    end else begin
      mini_q <= mini_d;
      full_q <= holdover_req_i;
      hold_q <= hold_d;
      if (freeze) frozen_q <= (src == SRC_AVG) ? avg_val : old_snap;
    end
  end

  assign hold_freq_o  = free_run_i ? mclk_offset_i : frozen_q;
  assign hold_ready_o = avg_ready;
  assign mini_hold_o  = mini_q;

  p_mini_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fail_i && !ref_active_i && !holdover_req_i) |=> mini_hold_o);
  p_mini_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_active_i || holdover_req_i) |=> !mini_hold_o);
  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && full_q == holdover_req_i && hold_d) |=> $stable(frozen_q));
  p_freerun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_run_i |-> (hold_freq_o == mclk_offset_i));
endmodule

// File: tb/test_holdover_freq_ctrl.sv
module test_holdover_freq_ctrl;
  localparam int unsigned FW = 16;
  localparam int unsigned NS = 5;
  localparam int unsigned RECIP = 65536 / NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [FW-1:0] integ = '0, offs = '0;
  logic tick = 0, locked = 0, rfail = 0, ract = 0, hreq = 0, frun = 0, avgm = 0, rclr = 0;
  logic [FW-1:0] hfreq;
  logic rdy, rdy_lat, mini;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  holdover_freq_ctrl #(.FREQ_W(FW), .SNAP_TICKS(2), .AVG_SNAPS(NS), .AVG_FRAC(16)) i_holdover_freq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .integ_freq_i(integ), .ms_tick_i(tick), .locked_i(locked),
    .ref_fail_i(rfail), .ref_active_i(ract), .holdover_req_i(hreq), .free_run_i(frun),
    .avg_mode_i(avgm), .mclk_offset_i(offs), .ready_clr_i(rclr), .hold_freq_o(hfreq),
    .hold_ready_o(rdy), .hold_ready_lat_o(rdy_lat), .mini_hold_o(mini));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic capture(input logic [FW-1:0] v);
    integ = v;
    tick = 1; cyc(); tick = 0; cyc();
    tick = 1; cyc(); tick = 0; cyc();
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; locked = 0; rfail = 0; ract = 0; hreq = 0;
    frun = 0; avgm = 0; rclr = 0; integ = '0;
    #7; @(negedge clk); rst_n = 1; cyc();
  endtask

  function automatic logic [FW-1:0] avg_of(input longint s);
    return FW'((s * RECIP) >> 16);
  endfunction

  function automatic logic [FW-1:0] val(input int s, input int k);
    return FW'((s * 9973 + k * 4099 + 17) & 16'hFFFF);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12
    chk("R12 freq", hfreq, 0); chk("R12 rdy", rdy, 0);
    chk("R12 lat", rdy_lat, 0); chk("R12 mini", mini, 0);

    // R1 R2 R6 snapshot age, unlocked captures skipped
    locked = 1;
    capture(100); capture(200);
    locked = 0; capture(999); locked = 1;
    capture(300);
    rfail = 1; cyc(); rfail = 0;
    chk("R6 mini set", mini, 1);
    chk("R2 older snapshot", hfreq, 200);
    capture(555); capture(666);   // R9 paused
    chk("R9 frozen", hfreq, 200);
    ract = 1; cyc(); ract = 0;
    chk("R7 mini exit active", mini, 0);
    rfail = 1; cyc(); rfail = 0;
    chk("R9 history paused", hfreq, 200);
    ract = 1; cyc(); ract = 0;
    capture(400);
    rfail = 1; ract = 1; cyc(); rfail = 0; ract = 0;
    chk("R6 blocked by active", mini, 0);

    // averaging sweeps
    for (int s = 0; s < 8; s++) begin
      longint sum;
      do_reset();
      locked = 1; avgm = 1; sum = 0;
      for (int k = 0; k < NS - 1; k++) begin capture(val(s, k)); sum += val(s, k); end
      chk("R3 not ready", rdy, 0);
      hreq = 1; cyc();
      chk("R4 fallback", hfreq, val(s, NS - 3));
      hreq = 0; cyc();
      capture(val(s, NS - 1)); sum += val(s, NS - 1);
      chk("R3 ready", rdy, 1);
      chk("R11 lat set", rdy_lat, 1);
      rfail = 1; cyc(); rfail = 0;
      chk("R6 mini snapshot in avg mode", hfreq, val(s, NS - 2));
      hreq = 1; cyc();
      chk("R7 mini exit full", mini, 0);
      chk("R8 promote to avg", hfreq, avg_of(sum));
      cyc();
      chk("R9 full stable", hfreq, avg_of(sum));
      avgm = 0; hreq = 0; cyc(); hreq = 1; cyc();
      chk("R2 instantaneous full", hfreq, val(s, NS - 2));
      hreq = 0; cyc();
    end

    // R10 partial window discarded
    do_reset();
    locked = 1; avgm = 1;
    capture(50000); capture(50000); capture(50000);
    locked = 0; cyc(); locked = 1;
    begin
      longint sum = 0;
      for (int k = 0; k < NS; k++) begin capture(FW'(10 + k * 3)); sum += 10 + k * 3; end
      chk("R10 ready after fresh window", rdy, 1);
      hreq = 1; cyc();
      chk("R10 avg of fresh window", hfreq, avg_of(sum));
      // R5 free-run overrides, avg bit ignored
      offs = 16'h1234; frun = 1; #1;
      chk("R5 free-run avg", hfreq, 16'h1234);
      avgm = 0; #1;
      chk("R5 free-run inst", hfreq, 16'h1234);
      offs = 16'h00AB; #1;
      chk("R5 offset follows", hfreq, 16'h00AB);
      frun = 0; hreq = 0; cyc();
    end

    // R11 set wins over clear, then clear
    do_reset();
    locked = 1; rclr = 1;
    for (int k = 0; k < NS; k++) capture(FW'(k));
    chk("R11 set over clear", rdy_lat, 1);
    cyc();
    chk("R11 clear", rdy_lat, 0);
    rclr = 0; cyc();
    chk("R11 stays clear", rdy_lat, 0);
    chk("R3 rt stays", rdy, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule